// File: doc/BRIEF.md
# Linked-List Queue Buffer Manager

This block keeps the address bookkeeping for a shared pool of fixed-size buffer cells that several packet queues draw from. A pointer memory holds one entry per cell, at the cell's own address, and that entry holds only the address of the next cell in whatever chain the cell belongs to. Every queue is a chain described by a head pointer, a tail pointer and a cell count. Unused cells form one more chain, the free list. The cell data itself lives elsewhere. This block only hands out and takes back cell addresses.

A write request names a queue. The block takes the address at the front of the free list, appends it to that queue and reports it, so the caller can store the cell there. A read request names a queue. The block reports the queue's head address, advances the head and gives the cell back to the free list. A parameter chooses how released cells return. In stack mode a released cell goes on top and is the next one handed out. In linked-list mode it goes to the back, so use is spread over all cells. In either mode an operation costs at most one pointer-memory read and one pointer-memory write. A single-port memory is shared between the two request ports by an arbiter that alternates when both are waiting. The per-queue counts are output so a scheduler can use them as weights.

Top module: `llq_buf_mgr`

## Requirements
- R1: After reset is released, `busy` stays high while every cell is chained into the free list in rising address order. `busy` falls NUM_CELLS+2 clock edges after the release, and at that point every queue length is zero. The first NUM_CELLS successful writes then receive addresses 0, 1, 2 and so on in that order.
- R2: A write to a queue while free cells remain reports the current free-list front address on `wr_addr`, with `wr_full`=0. It appends that address to the queue and raises that queue's length by one.
- R3: A read of a non-empty queue reports the queue's oldest address on `rd_addr`, with `rd_err`=0, and lowers its length by one. Within one queue, addresses come out in the order they were written.
- R4: A write when no free cell remains completes with `wr_full`=1. No queue length changes.
- R5: A read of an empty queue completes with `rd_err`=1. No queue length changes, and the next address handed out is unaffected.
- R6: With FREE_MODE=0 (stack), a cell released by a read is the very next address handed out by a write.
- R7: With FREE_MODE=1 (linked list), a released cell is handed out only after every cell that was already free.
- R8: A request is accepted on a clock edge when `busy` is low. Its done pulse (`wr_done` or `rd_done`) is high for exactly the next cycle, with `busy` high. The requester holds its request until it sees the pulse. The pointer memory is never read during the completion cycle.
- R9: When both requests wait at an accepting edge, the kind not served by the previous grant goes first (write first after reset). The other is served next, its done pulse arriving two cycles after the first.
- R10: After initialisation, the free cells plus the sum of all queue lengths always equal NUM_CELLS.
- R11: `q_len` carries queue q's cell count in bits [q*CW +: CW], with CW = clog2(NUM_CELLS+1). The counts are updated on the edge that ends the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_req | input | 1 | Write (allocate and append) request, held until `wr_done` |
| wr_qid | input | QW | Queue of the write request |
| rd_req | input | 1 | Read (take head and release) request, held until `rd_done` |
| rd_qid | input | QW | Queue of the read request |
| busy | output | 1 | Initialising or an operation in progress; no request accepted |
| wr_done | output | 1 | One-cycle completion pulse of a write |
| wr_full | output | 1 | With `wr_done`: refused, no free cell |
| wr_addr | output | AW | With `wr_done`: allocated cell address |
| rd_done | output | 1 | One-cycle completion pulse of a read |
| rd_err | output | 1 | With `rd_done`: refused, queue empty |
| rd_addr | output | AW | With `rd_done`: released head address |
| q_len | output | NUM_QUEUES*CW | Packed per-queue cell counts |

## Verification
Each result has a fixed due cycle. A request presented while the block is idle is accepted on the next rising edge, and its done pulse, address and flag are due in the cycle right after that edge. The lengths on `q_len` change on the edge that closes the done cycle. When both requests wait, the second completion is due two cycles after the first. Initialisation ends NUM_CELLS+2 edges after reset is released. The bench drives inputs and samples outputs on falling edges only. It counts falling edges from each stimulus and compares the count with these latencies. It reads the address, flag and lengths exactly in the cycle each is due, against a model of both free-list disciplines and of every queue.

// File: rtl/bm_pkg.sv
package bm_pkg;

  localparam int FREE_STACK  = 0;
  localparam int FREE_LINKED = 1;

  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_IDLE = 2'd1,
    ST_EXEC = 2'd2
  } bm_state_t;

  typedef enum logic {
    OP_WR = 1'b0,
    OP_RD = 1'b1
  } bm_op_t;

endpackage

// File: rtl/bm_ptr_ram.sv
module bm_ptr_ram #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] rdata
);

  logic [AW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        mem[addr] <= wdata;
      end else begin
        rdata <= mem[addr];
      end
    end
  end

endmodule

// File: rtl/bm_req_arbiter.sv
module bm_req_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic wr_req,
  input  logic rd_req,
  output logic gnt_wr,
  output logic gnt_rd
);

  logic wr_first_q, wr_first_n;

  always_comb begin
    gnt_wr     = idle && wr_req && (!rd_req || wr_first_q);
    gnt_rd     = idle && rd_req && (!wr_req || !wr_first_q);
    wr_first_n = wr_first_q;
    if (gnt_wr) wr_first_n = 1'b0;
    if (gnt_rd) wr_first_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_first_q <= 1'b1;
    end else begin
      wr_first_q <= wr_first_n;
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !(gnt_wr && gnt_rd)); // R9

  AST_GRANT_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_wr || gnt_rd) |=> !idle); // R9

endmodule

// File: rtl/bm_queue_table.sv
module bm_queue_table #(
  parameter int NQ = 4,
  parameter int AW = 4,
  parameter int CW = 5,
  parameter int QW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [QW-1:0]    upd_qid,
  input  logic [AW-1:0]    upd_head,
  input  logic [AW-1:0]    upd_tail,
  input  logic [CW-1:0]    upd_cnt,
  input  logic [QW-1:0]    sel_qid,
  output logic [AW-1:0]    sel_head,
  output logic [AW-1:0]    sel_tail,
  output logic [CW-1:0]    sel_cnt,
  output logic [NQ*CW-1:0] len_flat
);

  logic [AW-1:0] head_q [NQ];
  logic [AW-1:0] tail_q [NQ];
  logic [CW-1:0] cnt_q  [NQ];

  for (genvar gi = 0; gi < NQ; gi++) begin : g_queue
    logic hit;
    assign hit = upd_en && (upd_qid == QW'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        head_q[gi] <= '0;
        tail_q[gi] <= '0;
        cnt_q[gi]  <= '0;
      end else if (hit) begin
        head_q[gi] <= upd_head;
        tail_q[gi] <= upd_tail;
        cnt_q[gi]  <= upd_cnt;
      end
    end

    assign len_flat[gi*CW +: CW] = cnt_q[gi];
  end

  assign sel_head = head_q[sel_qid];
  assign sel_tail = tail_q[sel_qid];
  assign sel_cnt  = cnt_q[sel_qid];

endmodule

// File: rtl/llq_buf_mgr.sv
module llq_buf_mgr
  import bm_pkg::*;
#(
  parameter int NUM_CELLS  = 16,
  parameter int NUM_QUEUES = 4,
  parameter int FREE_MODE  = FREE_LINKED,
  localparam int AW = $clog2(NUM_CELLS),
  localparam int CW = $clog2(NUM_CELLS + 1),
  localparam int QW = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_req,
  input  logic [QW-1:0]            wr_qid,
  input  logic                     rd_req,
  input  logic [QW-1:0]            rd_qid,
  output logic                     busy,
  output logic                     wr_done,
  output logic                     wr_full,
  output logic [AW-1:0]            wr_addr,
  output logic                     rd_done,
  output logic                     rd_err,
  output logic [AW-1:0]            rd_addr,
  output logic [NUM_QUEUES*CW-1:0] q_len
);

  localparam int SW = CW + QW + 1;

  // reset: asserted at once, removed after two edges
  logic rst_s1, rst_s2, rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end
  assign rst_i_n = rst_s2;

  bm_state_t     state_q, state_n;
  bm_op_t        op_q, op_n;
  logic [QW-1:0] qid_q, qid_n;
  logic [AW-1:0] init_q, init_n;
  logic [AW-1:0] fh_q, fh_n;
  logic [AW-1:0] ft_q, ft_n;
  logic [CW-1:0] fc_q, fc_n;

  logic          gnt_wr, gnt_rd, idle;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr, mem_wdata, mem_rdata;

  logic          qt_upd;
  logic [AW-1:0] qt_head_n, qt_tail_n;
  logic [CW-1:0] qt_cnt_n;
  logic [QW-1:0] sel_qid;
  logic [AW-1:0] sel_head, sel_tail;
  logic [CW-1:0] sel_cnt;
  logic [SW-1:0] qsum;

  assign idle    = (state_q == ST_IDLE);
  assign sel_qid = (state_q == ST_EXEC) ? qid_q : rd_qid;

  bm_req_arbiter u_arb (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .idle   (idle),
    .wr_req (wr_req),
    .rd_req (rd_req),
    .gnt_wr (gnt_wr),
    .gnt_rd (gnt_rd)
  );

  bm_ptr_ram #(.DEPTH(NUM_CELLS), .AW(AW)) u_ptr (
    .clk   (clk),
    .en    (mem_en),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  bm_queue_table #(.NQ(NUM_QUEUES), .AW(AW), .CW(CW), .QW(QW)) u_qtab (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .upd_en   (qt_upd),
    .upd_qid  (qid_q),
    .upd_head (qt_head_n),
    .upd_tail (qt_tail_n),
    .upd_cnt  (qt_cnt_n),
    .sel_qid  (sel_qid),
    .sel_head (sel_head),
    .sel_tail (sel_tail),
    .sel_cnt  (sel_cnt),
    .len_flat (q_len)
  );

  // next-state logic
  always_comb begin
    state_n   = state_q;
    op_n      = op_q;
    qid_n     = qid_q;
    init_n    = init_q;
    fh_n      = fh_q;
    ft_n      = ft_q;
    fc_n      = fc_q;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    qt_upd    = 1'b0;
    qt_head_n = sel_head;
    qt_tail_n = sel_tail;
    qt_cnt_n  = sel_cnt;

    case (state_q)
      ST_INIT: begin
        // chain cell i to cell i+1
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = init_q;
        mem_wdata = init_q + 1'b1;
        init_n    = init_q + 1'b1;
        if (init_q == AW'(NUM_CELLS - 1)) begin
          state_n = ST_IDLE;
        end
      end

      ST_IDLE: begin
        if (gnt_wr) begin
          mem_en   = 1'b1;
          mem_addr = fh_q;
          op_n     = OP_WR;
          qid_n    = wr_qid;
          state_n  = ST_EXEC;
        end else if (gnt_rd) begin
          mem_en   = 1'b1;
          mem_addr = sel_head;
          op_n     = OP_RD;
          qid_n    = rd_qid;
          state_n  = ST_EXEC;
        end
      end

      ST_EXEC: begin
        state_n = ST_IDLE;
        if (op_q == OP_WR) begin
          if (fc_q != '0) begin
            qt_upd    = 1'b1;
            qt_tail_n = fh_q;
            qt_cnt_n  = sel_cnt + 1'b1;
            fh_n      = mem_rdata;
            fc_n      = fc_q - 1'b1;
            if (sel_cnt != '0) begin
              mem_en    = 1'b1;
              mem_we    = 1'b1;
              mem_addr  = sel_tail;
              mem_wdata = fh_q;
            end else begin
              qt_head_n = fh_q;
            end
          end
        end else if (sel_cnt != '0) begin
          qt_upd    = 1'b1;
          qt_head_n = mem_rdata;
          qt_cnt_n  = sel_cnt - 1'b1;
          fc_n      = fc_q + 1'b1;
          if (FREE_MODE == FREE_STACK) begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = sel_head;
            mem_wdata = fh_q;
            fh_n      = sel_head;
          end else begin
            ft_n = sel_head;
            if (fc_q != '0) begin
              mem_en    = 1'b1;
              mem_we    = 1'b1;
              mem_addr  = ft_q;
              mem_wdata = sel_head;
            end else begin
              fh_n = sel_head;
            end
          end
        end
      end

      default: state_n = ST_INIT;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_INIT;
      op_q    <= OP_WR;
      qid_q   <= '0;
      init_q  <= '0;
      fh_q    <= '0;
      ft_q    <= AW'(NUM_CELLS - 1);
      fc_q    <= CW'(NUM_CELLS);
    end else begin
      state_q <= state_n;
      op_q    <= op_n;
      qid_q   <= qid_n;
      init_q  <= init_n;
      fh_q    <= fh_n;
      ft_q    <= ft_n;
      fc_q    <= fc_n;
    end
  end

  assign busy    = !idle;
  assign wr_done = (state_q == ST_EXEC) && (op_q == OP_WR);
  assign rd_done = (state_q == ST_EXEC) && (op_q == OP_RD);
  assign wr_full = wr_done && (fc_q == '0);
  assign rd_err  = rd_done && (sel_cnt == '0);
  assign wr_addr = fh_q;
  assign rd_addr = sel_head;

  always_comb begin
    qsum = '0;
    for (int i = 0; i < NUM_QUEUES; i++) begin
      qsum = qsum + SW'(q_len[i*CW +: CW]);
    end
  end

  AST_EXEC_NO_READ: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((state_q == ST_EXEC) && mem_en) |-> mem_we); // R8

  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_done |-> $past(wr_req)) and (rd_done |-> $past(rd_req))); // R8

  AST_ALLOC_TAKES_CELL: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_done && !wr_full) |=> (fc_q == $past(fc_q) - 1'b1)); // R2

  AST_RELEASE_DROPS_LEN: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_done && !rd_err) |=> (qsum == $past(qsum) - 1'b1)); // R3

  AST_REFUSED_KEEPS_LEN: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_full || rd_err) |=> (qsum == $past(qsum))); // R4

  AST_CELLS_CONSERVED: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q != ST_INIT) |-> ((SW'(fc_q) + qsum) == SW'(NUM_CELLS))); // R10

endmodule

// File: tb/test_llq_buf_mgr.sv
module test_llq_buf_mgr;

  localparam int N  = 8;
  localparam int Q  = 4;
  localparam int CW = 4;

  logic clk;
  logic rst_n;
  logic wr_req, rd_req;
  logic [1:0] wr_qid, rd_qid;

  // index 0: linked-list free list, index 1: stack free list
  logic        busy    [2];
  logic        wr_done [2];
  logic        wr_full [2];
  logic [2:0]  wr_addr [2];
  logic        rd_done [2];
  logic        rd_err  [2];
  logic [2:0]  rd_addr [2];
  logic [15:0] q_len   [2];

  llq_buf_mgr #(.NUM_CELLS(N), .NUM_QUEUES(Q), .FREE_MODE(bm_pkg::FREE_LINKED)) i_llq_buf_mgr (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_qid(wr_qid), .rd_req(rd_req), .rd_qid(rd_qid),
    .busy(busy[0]), .wr_done(wr_done[0]), .wr_full(wr_full[0]), .wr_addr(wr_addr[0]),
    .rd_done(rd_done[0]), .rd_err(rd_err[0]), .rd_addr(rd_addr[0]), .q_len(q_len[0]));

  llq_buf_mgr #(.NUM_CELLS(N), .NUM_QUEUES(Q), .FREE_MODE(bm_pkg::FREE_STACK)) i_llq_buf_mgr_stk (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_qid(wr_qid), .rd_req(rd_req), .rd_qid(rd_qid),
    .busy(busy[1]), .wr_done(wr_done[1]), .wr_full(wr_full[1]), .wr_addr(wr_addr[1]),
    .rd_done(rd_done[1]), .rd_err(rd_err[1]), .rd_addr(rd_addr[1]), .q_len(q_len[1]));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk;
  int n_fail;
  int fl [2][N];
  int fc [2];
  int qa [2][Q][N];
  int qc [2][Q];
  int last_wa [2];
  int last_ra [2];
  bit pref_wr;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic check_len(input string rq);
    for (int m = 0; m < 2; m++) begin
      for (int q = 0; q < Q; q++) begin
        chk(rq, "q_len field", int'(q_len[m][q*CW +: CW]), qc[m][q]);
      end
    end
  endtask

  task automatic take_wr(input int q);
    for (int m = 0; m < 2; m++) begin
      chk("R8", "wr_done", int'(wr_done[m]), 1);
      chk("R8", "busy at done", int'(busy[m]), 1);
      last_wa[m] = int'(wr_addr[m]);
      if (fc[m] == 0) begin
        chk("R4", "wr_full", int'(wr_full[m]), 1);
      end else begin
        chk("R4", "wr_full", int'(wr_full[m]), 0);
        chk("R2", "wr_addr", int'(wr_addr[m]), fl[m][0]);
        qa[m][q][qc[m][q]] = fl[m][0];
        qc[m][q]++;
        for (int i = 0; i < N - 1; i++) fl[m][i] = fl[m][i+1];
        fc[m]--;
      end
    end
    pref_wr = 1'b0;
  endtask

  task automatic take_rd(input int q);
    int h;
    for (int m = 0; m < 2; m++) begin
      chk("R8", "rd_done", int'(rd_done[m]), 1);
      last_ra[m] = int'(rd_addr[m]);
      if (qc[m][q] == 0) begin
        chk("R5", "rd_err", int'(rd_err[m]), 1);
      end else begin
        chk("R5", "rd_err", int'(rd_err[m]), 0);
        h = qa[m][q][0];
        chk("R3", "rd_addr", int'(rd_addr[m]), h);
        for (int i = 0; i < N - 1; i++) qa[m][q][i] = qa[m][q][i+1];
        qc[m][q]--;
        if (m == 1) begin
          for (int i = N - 1; i > 0; i--) fl[m][i] = fl[m][i-1];
          fl[m][0] = h;
        end else begin
          fl[m][fc[m]] = h;
        end
        fc[m]++;
      end
    end
    pref_wr = 1'b1;
  endtask

  task automatic do_wr(input int q);
    int k;
    wr_qid = 2'(q);
    wr_req = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!wr_done[0] && k < 20);
    chk("R8", "write latency", k, 1);
    if (wr_done[0]) take_wr(q);
    wr_req = 1'b0;
    @(negedge clk);
    check_len("R11");
  endtask

  task automatic do_rd(input int q);
    int k;
    rd_qid = 2'(q);
    rd_req = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!rd_done[0] && k < 20);
    chk("R8", "read latency", k, 1);
    if (rd_done[0]) take_rd(q);
    rd_req = 1'b0;
    @(negedge clk);
    check_len("R11");
  endtask

  task automatic do_both(input int qw, input int qr);
    int k;
    bit first_wr;
    wr_qid = 2'(qw);
    rd_qid = 2'(qr);
    wr_req = 1'b1;
    rd_req = 1'b1;
    first_wr = pref_wr;
    k = 0;
    do begin @(negedge clk); k++; end while (!wr_done[0] && !rd_done[0] && k < 20);
    chk("R8", "first latency", k, 1);
    chk("R9", "first served is write", int'(wr_done[0]), int'(first_wr));
    chk("R9", "served alike in both modes", int'(wr_done[1]), int'(wr_done[0]));
    if (wr_done[0]) begin
      take_wr(qw);
      wr_req = 1'b0;
    end else if (rd_done[0]) begin
      take_rd(qr);
      rd_req = 1'b0;
    end
    k = 0;
    do begin @(negedge clk); k++; end while (!wr_done[0] && !rd_done[0] && k < 20);
    chk("R9", "second latency", k, 2);
    if (wr_done[0]) begin
      take_wr(qw);
      wr_req = 1'b0;
    end else if (rd_done[0]) begin
      take_rd(qr);
      rd_req = 1'b0;
    end
    wr_req = 1'b0;
    rd_req = 1'b0;
    @(negedge clk);
    check_len("R11");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog expired: actual 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    int k;
    int s;
    logic [15:0] lf;
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    wr_req = 1'b0;
    rd_req = 1'b0;
    wr_qid = '0;
    rd_qid = '0;
    pref_wr = 1'b1;
    for (int m = 0; m < 2; m++) begin
      fc[m] = N;
      for (int i = 0; i < N; i++) fl[m][i] = i;
      for (int q = 0; q < Q; q++) qc[m][q] = 0;
    end

    // R1: initialisation
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", int'(busy[0]), 1);
    rst_n = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (busy[0] && k < 100);
    chk("R1", "init edges", k, N + 2);
    chk("R1", "stack mode ready too", int'(busy[1]), 0);
    check_len("R1");

    // R1/R2: fill, addresses in rising order
    for (int i = 0; i < N; i++) begin
      do_wr(i % Q);
      for (int m = 0; m < 2; m++) chk("R1", "first-pass address", last_wa[m], i);
    end
    for (int m = 0; m < 2; m++) begin
      s = 0;
      for (int q = 0; q < Q; q++) s += int'(q_len[m][q*CW +: CW]);
      chk("R10", "cells held by queues when full", s, N);
    end

    // R4: no free cell
    do_wr(0);
    for (int m = 0; m < 2; m++) chk("R4", "q0 length kept", int'(q_len[m][0 +: CW]), 2);

    // R3/R5: drain queue 3, then read it empty
    do_rd(3);
    do_rd(3);
    do_rd(3);
    for (int m = 0; m < 2; m++) chk("R5", "q3 stays empty", int'(q_len[m][3*CW +: CW]), 0);
    do_wr(3);

    // R6/R7: reuse of a released cell
    do_rd(0);
    do_wr(1);
    chk("R6", "stack reuses released cell", last_wa[1], last_ra[1]);
    chk("R7", "linked list defers released cell", int'(last_wa[0] == last_ra[0]), 0);

    // R9: both requests at once, both orders
    do_both(2, 1);
    do_both(2, 1);

    // R3: drain everything in FIFO order
    for (int q = 0; q < Q; q++) begin
      while (qc[0][q] > 0) do_rd(q);
    end
    do_rd(2);

    // sweep over a long mixed sequence
    lf = 16'hACE1;
    for (int t = 0; t < 400; t++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[3:0] < 4'd7)       do_wr(int'(lf[5:4]));
      else if (lf[3:0] < 4'd13) do_rd(int'(lf[5:4]));
      else                      do_both(int'(lf[5:4]), int'(lf[7:6]));
    end
    for (int m = 0; m < 2; m++) begin
      s = 0;
      for (int q = 0; q < Q; q++) s += int'(q_len[m][q*CW +: CW]);
      chk("R10", "cells conserved after sweep", s + fc[m], N);
    end

    summary();
    $finish;
  end

endmodule